// File: doc/BRIEF.md
# Warp Group Barrier Unit

This unit provides the hardware side of block-wide barriers in a SIMT core. Software first programs how many warps make up one thread block. That count is a power of two, and warps are handed out to blocks in contiguous order of warp id. Each warp then signals when it reaches a barrier. Once every warp of its block has signalled, the unit releases that whole block with a one-cycle pulse on each member warp's release line. Blocks are independent of each other. A barrier in one block never waits on, and never frees, warps of another block.

The unit keeps one pending-arrival flag per warp. In each cycle it merges the stored flags with the arrivals of that cycle and checks every block for completion. It issues the release pulses and clears the released flags in the same clock edge. A configuration write whose value is not a power of two within range is rejected: the unit flags it and keeps the previous grouping. A kernel-start strobe discards all pending arrivals.

Top module: `warp_group_barrier`

## Requirements
- R1: After reset, every release line and the error flag are low, no arrival is pending, and all warps form a single block.
- R2: A configuration write of a power of two between 1 and the warp count sets the warps-per-block value, and it governs grouping from the following clock edge on.
- R3: A configuration write of zero, a non-power-of-two, or a value above the warp count makes the error flag high for exactly one cycle after the write edge and leaves the grouping unchanged.
- R4: Warp w belongs to block w >> log2(warps-per-block). When the last missing warp of a block arrives, all warps of that block see their release line high for exactly one cycle, starting after the clock edge that samples that arrival.
- R5: Completing one block does not release any warp of another block, and a block's release does not depend on arrivals outside it.
- R6: A warp that signals arrival more than once before its block is released counts once; its repeats neither complete the block early nor cause a second release.
- R7: Released warps have their pending flags cleared at the release edge, so an arrival during the release pulse cycle starts a new barrier round.
- R8: A kernel-start strobe clears every pending arrival, ignores arrivals presented in the same cycle, and produces no release on that edge.
- R9: With one warp per block, each arriving warp is released one cycle later, and several blocks may be released in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_warps | input | CFG_W | Requested warps per block |
| cfg_err | output | 1 | One-cycle pulse after a rejected configuration write |
| kernel_start | input | 1 | Kernel start strobe; discards pending arrivals |
| bar_arrive | input | NUM_WARPS | Per-warp barrier arrival request |
| bar_release | output | NUM_WARPS | Per-warp one-cycle release pulse |

## Verification
The bench targets partial blocks that must stay held. If the block boundaries were derived wrongly, a neighbouring block would be released early or never. It targets repeated arrivals from one warp, which a counting design would mistake for a completed block. It also targets arrivals in the very cycle of a release, which are lost if the pending flags are cleared one edge too late. Rejected settings of zero, three and above the warp count are followed by arrivals that only complete under the old grouping, so an implementation that applied a bad value would be exposed. A kernel start with arrivals in the same cycle shows whether stale or simultaneous arrivals leak into the next round. One-warp and two-warp blocks with many simultaneous completions exercise the extremes of the grouping.

// File: rtl/wgb_pkg.sv
// Package: shared helpers for the warp group barrier unit.
// Assumes configuration values fit in 32 bits.
package wgb_pkg;

    // Returns 1 when v is a nonzero power of two.
    function automatic logic is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // Returns the index of the highest set bit of v (0 for v == 0).
    function automatic int unsigned msb_index(input int unsigned v);
        int unsigned idx;
        idx = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/wgb_cfg_reg.sv
// Module: wgb_cfg_reg
// Holds the block size as a log2 value. Accepts a write only when the
// value is a power of two no larger than NUM_WARPS; otherwise it pulses
// cfg_err for one cycle and keeps the old value.
// Assumes NUM_WARPS is a power of two.
module wgb_cfg_reg
    import wgb_pkg::*;
#(
    parameter int NUM_WARPS = 16,
    parameter int CFG_W     = $clog2(NUM_WARPS) + 2,
    parameter int LVL_W     = $clog2($clog2(NUM_WARPS) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [CFG_W-1:0] cfg_warps,
    output logic [LVL_W-1:0] grp_lvl,
    output logic             cfg_err
);
    localparam int WID_W = $clog2(NUM_WARPS);

    logic             val_ok;
    logic [LVL_W-1:0] val_lvl;

    // Classify the requested value and encode its log2.
    always_comb begin
        val_ok  = is_pow2(32'(cfg_warps)) && (32'(cfg_warps) <= NUM_WARPS);
        val_lvl = LVL_W'(msb_index(32'(cfg_warps)));
    end

    // Register the grouping level and the rejection pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_lvl <= LVL_W'(WID_W);
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= cfg_valid && !val_ok;
            if (cfg_valid && val_ok) grp_lvl <= val_lvl;
        end
    end
endmodule

// File: rtl/wgb_group_detect.sv
// Module: wgb_group_detect
// Combinational completion detector. For each possible block size it
// finds blocks whose warps are all pending and spreads that result to
// every member; grp_lvl picks which size is in force.
// Assumes grp_lvl never exceeds log2(NUM_WARPS).
module wgb_group_detect #(
    parameter int NUM_WARPS = 16,
    parameter int LVL_W     = $clog2($clog2(NUM_WARPS) + 1)
) (
    input  logic [NUM_WARPS-1:0] pend,
    input  logic [LVL_W-1:0]     grp_lvl,
    output logic [NUM_WARPS-1:0] done
);
    localparam int WID_W = $clog2(NUM_WARPS);

    logic [WID_W:0][NUM_WARPS-1:0] done_by_lvl;

    // One detector per block size, one AND-reduction per block.
    for (genvar l = 0; l <= WID_W; l++) begin : g_lvl
        localparam int SZ = 1 << l;
        for (genvar g = 0; g < NUM_WARPS / SZ; g++) begin : g_blk
            assign done_by_lvl[l][g*SZ +: SZ] = {SZ{&pend[g*SZ +: SZ]}};
        end
    end

    // Select the detector matching the configured block size.
    always_comb begin
        done = '0;
        for (int i = 0; i <= WID_W; i++) begin
            if (grp_lvl == LVL_W'(i)) done = done_by_lvl[i];
        end
    end
endmodule

// File: rtl/wgb_arrival_track.sv
// Module: wgb_arrival_track
// Keeps one pending flag per warp and the registered release pulses.
// Exposes the merged pending vector for the completion detector.
// Assumes done is a function of pend only (no loop through this module).
module wgb_arrival_track #(
    parameter int NUM_WARPS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 kernel_start,
    input  logic [NUM_WARPS-1:0] bar_arrive,
    input  logic [NUM_WARPS-1:0] done,
    output logic [NUM_WARPS-1:0] pend,
    output logic [NUM_WARPS-1:0] arr_q,
    output logic [NUM_WARPS-1:0] go_q
);
    // Merge stored flags with this cycle's arrivals; repeats collapse.
    always_comb begin
        pend = arr_q | bar_arrive;
    end

    // Update pending flags and release pulses; a kernel start wipes both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_q <= '0;
            go_q  <= '0;
        end else if (kernel_start) begin
            arr_q <= '0;
            go_q  <= '0;
        end else begin
            arr_q <= pend & ~done;
            go_q  <= done;
        end
    end
endmodule

// File: rtl/warp_group_barrier.sv
// Module: warp_group_barrier (top)
// Block-wide barrier for the warps of a SIMT core. Warps are grouped
// contiguously into blocks of a configured power-of-two size; a block is
// released with a one-cycle pulse per warp once all its warps arrived.
// Assumes NUM_WARPS is a power of two and at least 2.
module warp_group_barrier #(
    parameter int NUM_WARPS = 16,
    parameter int CFG_W     = $clog2(NUM_WARPS) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic [CFG_W-1:0]     cfg_warps,
    output logic                 cfg_err,
    input  logic                 kernel_start,
    input  logic [NUM_WARPS-1:0] bar_arrive,
    output logic [NUM_WARPS-1:0] bar_release
);
    localparam int LVL_W = $clog2($clog2(NUM_WARPS) + 1);

    logic [LVL_W-1:0]     grp_lvl;
    logic [NUM_WARPS-1:0] pend;
    logic [NUM_WARPS-1:0] done;
    logic [NUM_WARPS-1:0] arr_q;
    logic [NUM_WARPS-1:0] go_q;

    // Block size register with rejection of bad values.
    wgb_cfg_reg #(
        .NUM_WARPS(NUM_WARPS), .CFG_W(CFG_W), .LVL_W(LVL_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
        .cfg_warps(cfg_warps), .grp_lvl(grp_lvl), .cfg_err(cfg_err)
    );

    // Pending flags and release register.
    wgb_arrival_track #(.NUM_WARPS(NUM_WARPS)) u_arr (
        .clk(clk), .rst_n(rst_n), .kernel_start(kernel_start),
        .bar_arrive(bar_arrive), .done(done), .pend(pend),
        .arr_q(arr_q), .go_q(go_q)
    );

    // Per-block completion detection.
    wgb_group_detect #(.NUM_WARPS(NUM_WARPS), .LVL_W(LVL_W)) u_det (
        .pend(pend), .grp_lvl(grp_lvl), .done(done)
    );

    assign bar_release = go_q;
endmodule

// File: rtl/wgb_checker.sv
// Module: wgb_checker
// Property checks for warp_group_barrier, attached with bind below.
module wgb_checker #(
    parameter int NUM_WARPS = 16,
    parameter int CFG_W     = $clog2(NUM_WARPS) + 2,
    parameter int LVL_W     = $clog2($clog2(NUM_WARPS) + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_valid,
    input logic                 cfg_err,
    input logic                 kernel_start,
    input logic [NUM_WARPS-1:0] bar_arrive,
    input logic [NUM_WARPS-1:0] bar_release,
    input logic [LVL_W-1:0]     grp_lvl,
    input logic [NUM_WARPS-1:0] arr_q
);
    a_r3_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_valid));

    a_r3_bad_cfg_keeps_grouping: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $stable(grp_lvl));

    a_r2_grouping_changes_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(grp_lvl) |-> $past(cfg_valid));

    a_r4_whole_blocks_released: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_release != '0) |->
            (($countones(bar_release) % (1 << $past(grp_lvl))) == 0));

    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kernel_start) |-> (arr_q == '0 && bar_release == '0));

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
        a_r6_release_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
            bar_release[w] |-> $past(arr_q[w] | bar_arrive[w]));
    end
endmodule

bind warp_group_barrier wgb_checker #(
    .NUM_WARPS(NUM_WARPS), .CFG_W(CFG_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_err(cfg_err),
    .kernel_start(kernel_start), .bar_arrive(bar_arrive),
    .bar_release(bar_release), .grp_lvl(grp_lvl), .arr_q(arr_q)
);

// File: tb/warp_group_barrier_test.sv
module warp_group_barrier_test;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 16;
    localparam int CW = $clog2(NW) + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [CW-1:0] cfg_warps = '0;
    logic          kernel_start = 1'b0;
    logic [NW-1:0] arrive = '0;
    logic          err;
    logic [NW-1:0] go;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    int      ref_wpb = NW;
    bit [NW-1:0] ref_arr = '0;
    bit [NW-1:0] exp_go = '0;
    bit          exp_err = 1'b0;

    warp_group_barrier #(.NUM_WARPS(NW), .CFG_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_warps(cfg_warps),
        .cfg_err(err), .kernel_start(kernel_start), .bar_arrive(arrive),
        .bar_release(go)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [NW-1:0] got, logic [NW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Behavioural model of one clock edge from the requirements.
    task automatic model_edge();
        int v;
        bit ok;
        bit all;
        bit [NW-1:0] pend;
        v = int'(cfg_warps);
        ok = cfg_valid && v > 0 && v <= NW && ((v & (v - 1)) == 0);
        exp_err = cfg_valid && !ok;
        exp_go = '0;
        if (kernel_start) begin
            ref_arr = '0;
        end else begin
            pend = ref_arr | arrive;
            for (int g = 0; g < NW / ref_wpb; g++) begin
                all = 1'b1;
                for (int k = 0; k < ref_wpb; k++)
                    if (!pend[g*ref_wpb + k]) all = 1'b0;
                if (all)
                    for (int k = 0; k < ref_wpb; k++) begin
                        exp_go[g*ref_wpb + k] = 1'b1;
                        pend[g*ref_wpb + k] = 1'b0;
                    end
            end
            ref_arr = pend;
        end
        if (ok) ref_wpb = v;
    endtask

    // Drive one cycle of inputs, advance model, compare at the falling edge.
    task automatic cyc(string tag, logic [NW-1:0] arr, bit ks = 0, bit cv = 0, int cw = 0);
        arrive = arr;
        kernel_start = ks;
        cfg_valid = cv;
        cfg_warps = CW'(cw);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " release"}, go, exp_go);
        check({tag, " cfg_err"}, NW'(err), NW'(exp_err));
        arrive = '0;
        kernel_start = 1'b0;
        cfg_valid = 1'b0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 5000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 reset release", go, '0);
        check("R1 reset cfg_err", NW'(err), '0);

        // R1/R4: default is one block of all warps
        cyc("R1 default partial", 16'h00FF);
        cyc("R1 default partial2", 16'h7F00);
        cyc("R4 default complete", 16'h8000);
        cyc("R4 pulse ends", '0);

        // R2: four warps per block
        cyc("R2 cfg 4", '0, 0, 1, 4);
        cyc("R5 other block partial", 16'h0010);
        cyc("R6 repeat w0", 16'h0001);
        cyc("R6 repeat w0 again", 16'h0001);
        cyc("R6 w1 w2", 16'h0006);
        cyc("R5 complete block0 only", 16'h0008);
        cyc("R5 pulse ends", '0);
        cyc("R5 complete block1", 16'h00E0);
        cyc("R5 idle", '0);

        // R3: rejected settings keep grouping of four
        cyc("R3 cfg 3", '0, 0, 1, 3);
        cyc("R3 cfg 0", '0, 0, 1, 0);
        cyc("R3 cfg 20", '0, 0, 1, 20);
        cyc("R3 grouping kept", 16'h0F00);
        cyc("R3 idle", '0);

        // R7: arrival in the release cycle starts a new round
        cyc("R7 first half", 16'h0300);
        cyc("R7 complete", 16'h0C00);
        cyc("R7 rearrive in pulse", 16'h0100);
        cyc("R7 not early", 16'h0600);
        cyc("R7 second round", 16'h0800);
        cyc("R7 idle", '0);

        // R8: kernel start clears pending and ignores same-cycle arrivals
        cyc("R8 pending", 16'h3000);
        cyc("R8 start with arrivals", 16'hC000, 1);
        cyc("R8 old cleared", 16'hC000);
        cyc("R8 new round completes", 16'h3000);
        cyc("R8 idle", '0);

        // R9: one warp per block
        cyc("R9 cfg 1", '0, 0, 1, 1);
        cyc("R9 pattern", 16'hA5A5);
        cyc("R9 pattern2", 16'h5A5A);
        cyc("R9 idle", '0);

        // R2: two warps per block, several completions at once
        cyc("R2 cfg 2", '0, 0, 1, 2);
        cyc("R2 multi", 16'b0011_0001_1100_0011);
        cyc("R2 multi finish", 16'b1100_0010_0000_0000);
        cyc("R2 cfg with arrivals", 16'h0001, 0, 1, 8);
        cyc("R2 new size", 16'h00FE);
        cyc("R2 idle", '0);

        // R4: mixed random traffic against the model
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 39);
            if (r == 0)
                cyc("R4 random cfg", NW'($urandom), 0, 1, $urandom_range(0, 20));
            else if (r == 1)
                cyc("R8 random start", NW'($urandom), 1);
            else
                cyc("R4 random", NW'($urandom) & NW'($urandom));
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule